// File: doc/BRIEF.md
# Segment Address Translator

This block turns a 16-bit segment selector and an offset into a 32-bit linear address. The selector picks one 8-byte descriptor from one of two tables: the global table or the local table. The block reads that descriptor over a simple memory read port. It then checks the offset against the segment limit and returns the descriptor base plus the offset, together with the descriptor's two access bytes and the selector's requested privilege level.

Software first programs the global table's base and limit. It then writes a local-table selector. This selector picks a global-table descriptor, and that descriptor's base and limit become the local table. Each command (local load or translation) finishes with a one-cycle done pulse. Any bound violation raises fault on that pulse, and the address output is then zero.

Top module: `segxl_unit`

## Requirements
- R1: The selector has these fields: bits [15:3] are the table index, bit 2 picks the table (0 = global, 1 = local), and bits [1:0] are the requested privilege level. The privilege level is returned on `rpl_out` with done.
- R2: A descriptor is read as two memory words. The first request goes to table base + index*8 and the second to that address + 4.
- R3: The descriptor's first word is the segment base. Bits [15:0] of the second word are the segment limit, and bits [31:16] are the access bytes. A translation that passes its checks returns base + offset on `lin_addr` and the access bytes on `attr_out`.
- R4: An offset larger than the segment limit raises fault, and `lin_addr` and `attr_out` are then zero. An offset equal to the limit is accepted.
- R5: If index*8+7 exceeds the limit of the chosen table, the block raises fault and issues no memory request.
- R6: Writing a local-table selector reads the global-table entry it indexes, ignoring its bit 2. The block then caches that entry's base and limit as the local table and reports the base on `lin_addr` with done. If the global bound check fails, the block faults and the local table becomes unloaded.
- R7: A translation with bit 2 = 1 while the local table is unloaded (after reset or after a failed load) raises fault with no memory request.
- R8: While `busy` is high, every command input is ignored. In an idle cycle, a global-table write takes priority over a local-selector write, and a local-selector write takes priority over a translation. Only the winning command is acted on.
- R9: After reset, `busy`, `done`, `fault` and `mrd_valid` are low, and the global table has base 0 and limit 0.
- R10: Each accepted load or translation gives exactly one one-cycle done pulse. `fault` is high only together with `done`. A global-table write gives no pulse.
- R11: `mrd_valid` is high only while `busy` is high. Once raised, it holds with a stable `mrd_addr` until `mrd_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gtab_wr | input | 1 | Write the global table base and limit |
| gtab_base_in | input | 32 | New global table base |
| gtab_lim_in | input | 16 | New global table limit |
| ltsel_wr | input | 1 | Load the local table from the global entry that `ltsel_in` selects |
| ltsel_in | input | 16 | Local-table selector |
| xl_go | input | 1 | Start a translation |
| xl_sel | input | 16 | Selector to translate |
| xl_off | input | OFF_W | Offset within the segment |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The completing command failed a check |
| lin_addr | output | 32 | Linear address (or loaded local-table base) |
| attr_out | output | 16 | Descriptor access bytes |
| rpl_out | output | 2 | Requested privilege level of the selector |
| mrd_valid | output | 1 | Memory read request |
| mrd_addr | output | 32 | Memory read byte address |
| mrd_ready | input | 1 | Memory accepts the request |
| mrd_rvalid | input | 1 | Read data valid |
| mrd_rdata | input | MEM_W | Read data |

## Verification
The bound checker watches several properties on every cycle. It checks that done is a single-cycle pulse and that fault never appears without it. It checks that a faulted result carries a zero address. It checks that memory requests appear only while busy and hold a stable address until accepted. Everything that depends on table contents can only be shown by the bench scenarios run against a reference model of the tables in the bench's own memory. This covers the chosen descriptor address, the base-plus-offset sum, the limit edges, the local-table load and loss, and the ignoring of commands while busy.

// File: rtl/segxl_pkg.sv
`timescale 1ns/1ps
package segxl_pkg;
   localparam int SEL_W  = 16;
   localparam int IDX_W  = SEL_W - 3;
   localparam int BASE_W = 32;
   localparam int LIM_W  = 16;
   localparam int ATTR_W = 16;
   localparam int DESC_W = BASE_W + LIM_W + ATTR_W;

   // index [15:3], table pick [2], privilege [1:0]
   typedef struct packed {
      logic [IDX_W-1:0] idx;
      logic             tloc;
      logic [1:0]       rpl;
   } sel_t;

   // first word = base, second word = {attr, limit}
   typedef struct packed {
      logic [ATTR_W-1:0] attr;
      logic [LIM_W-1:0]  lim;
      logic [BASE_W-1:0] base;
   } desc_t;

   typedef struct packed {
      logic [BASE_W-1:0] base;
      logic [LIM_W-1:0]  lim;
   } tab_t;

   function automatic logic entry_out(input logic [IDX_W-1:0] idx, input logic [LIM_W-1:0] lim);
      logic [BASE_W-1:0] last_byte;
      last_byte = BASE_W'({idx, 3'b111});
      return last_byte > BASE_W'(lim);
   endfunction

   function automatic logic [BASE_W-1:0] entry_addr(input logic [BASE_W-1:0] base, input logic [IDX_W-1:0] idx);
      return base + BASE_W'({idx, 3'b000});
   endfunction
endpackage

// File: rtl/segxl_tabs.sv
`timescale 1ns/1ps
module segxl_tabs
   import segxl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gwr,
   input  logic [BASE_W-1:0] gbase,
   input  logic [LIM_W-1:0]  glim,
   input  logic              lld,
   input  logic              lfail,
   input  tab_t              lnew,
   output tab_t              gtab,
   output tab_t              ltab,
   output logic              lvld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gtab <= '0;
         ltab <= '0;
         lvld <= 1'b0;
      end else begin
         if (gwr) begin
            gtab.base <= gbase;
            gtab.lim  <= glim;
         end
         if (lld) begin
            ltab <= lnew;
            lvld <= 1'b1;
         end else if (lfail) begin
            lvld <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/segxl_fetch.sv
`timescale 1ns/1ps
module segxl_fetch
   import segxl_pkg::*;
#(
   parameter int MEM_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BASE_W-1:0] addr,
   output logic              mrd_valid,
   output logic [BASE_W-1:0] mrd_addr,
   input  logic              mrd_ready,
   input  logic              mrd_rvalid,
   input  logic [MEM_W-1:0]  mrd_rdata,
   output logic              fdone,
   output logic [DESC_W-1:0] fdesc
);
   localparam int BEATS = DESC_W / MEM_W;
   localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int STEP  = MEM_W / 8;

   initial begin
      assert (MEM_W == 32 || MEM_W == 64)
         else $error("segxl_fetch: MEM_W must be 32 or 64");
   end

   typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_e;

   fst_e              st;
   logic [BW-1:0]     beat;
   logic [BASE_W-1:0] base_q;
   logic [DESC_W-1:0] buf_q;
   logic              last;

   generate
      if (BEATS == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_multi
         assign last = (beat == BW'(BEATS - 1));
      end
   endgenerate

   assign mrd_valid = (st == F_REQ);
   assign mrd_addr  = base_q + BASE_W'(beat) * BASE_W'(STEP);
   assign fdesc     = buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= F_IDLE;
         beat   <= '0;
         base_q <= '0;
         buf_q  <= '0;
         fdone  <= 1'b0;
      end else begin
         fdone <= 1'b0;
         case (st)
            F_IDLE: begin
               if (start) begin
                  base_q <= addr;
                  beat   <= '0;
                  st     <= F_REQ;
               end
            end
            F_REQ: begin
               if (mrd_ready) st <= F_WAIT;
            end
            F_WAIT: begin
               if (mrd_rvalid) begin
                  buf_q[beat*MEM_W +: MEM_W] <= mrd_rdata;
                  if (last) begin
                     fdone <= 1'b1;
                     st    <= F_IDLE;
                  end else begin
                     beat <= beat + 1'b1;
                     st   <= F_REQ;
                  end
               end
            end
            default: st <= F_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/segxl_ctrl.sv
`timescale 1ns/1ps
module segxl_ctrl
   import segxl_pkg::*;
#(
   parameter int OFF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gwr,
   input  logic              lwr,
   input  logic [SEL_W-1:0]  lsel,
   input  logic              go,
   input  logic [SEL_W-1:0]  xsel,
   input  logic [OFF_W-1:0]  xoff,
   input  tab_t              gtab,
   input  tab_t              ltab,
   input  logic              lvld,
   input  logic              fdone,
   input  logic [DESC_W-1:0] fdesc,
   output logic              fstart,
   output logic [BASE_W-1:0] faddr,
   output logic              gwr_ok,
   output logic              lld,
   output logic              lfail,
   output tab_t              lnew,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [BASE_W-1:0] lin,
   output logic [ATTR_W-1:0] attr,
   output logic [1:0]        rpl
);
   typedef enum logic [1:0] {C_IDLE, C_CHK, C_FETCH} cst_e;

   cst_e             st;
   sel_t             sel_q;
   logic [OFF_W-1:0] off_q;
   logic             op_ld;
   tab_t             tab_use;
   logic             nolt;
   logic             oob;
   logic             off_bad;
   desc_t            d;

   assign d = desc_t'(fdesc);

   always_comb begin
      tab_use = (!op_ld && sel_q.tloc) ? ltab : gtab;
      nolt    = !op_ld && sel_q.tloc && !lvld;
      oob     = entry_out(sel_q.idx, tab_use.lim);
      off_bad = BASE_W'(off_q) > BASE_W'(d.lim);
   end

   assign busy      = (st != C_IDLE);
   assign gwr_ok    = gwr && (st == C_IDLE);
   assign fstart    = (st == C_CHK) && !nolt && !oob;
   assign faddr     = entry_addr(tab_use.base, sel_q.idx);
   assign lld       = (st == C_FETCH) && fdone && op_ld;
   assign lfail     = (st == C_CHK) && op_ld && oob;
   assign lnew.base = d.base;
   assign lnew.lim  = d.lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= C_IDLE;
         sel_q <= '0;
         off_q <= '0;
         op_ld <= 1'b0;
         done  <= 1'b0;
         fault <= 1'b0;
         lin   <= '0;
         attr  <= '0;
         rpl   <= '0;
      end else begin
         done  <= 1'b0;
         fault <= 1'b0;
         case (st)
            C_IDLE: begin
               if (!gwr) begin
                  if (lwr) begin
                     sel_q <= sel_t'(lsel);
                     op_ld <= 1'b1;
                     st    <= C_CHK;
                  end else if (go) begin
                     sel_q <= sel_t'(xsel);
                     off_q <= xoff;
                     op_ld <= 1'b0;
                     st    <= C_CHK;
                  end
               end
            end
            C_CHK: begin
               if (nolt || oob) begin
                  st    <= C_IDLE;
                  done  <= 1'b1;
                  fault <= 1'b1;
                  lin   <= '0;
                  attr  <= '0;
                  rpl   <= sel_q.rpl;
               end else begin
                  st <= C_FETCH;
               end
            end
            C_FETCH: begin
               if (fdone) begin
                  st   <= C_IDLE;
                  done <= 1'b1;
                  rpl  <= sel_q.rpl;
                  if (op_ld) begin
                     lin  <= d.base;
                     attr <= d.attr;
                  end else if (off_bad) begin
                     fault <= 1'b1;
                     lin   <= '0;
                     attr  <= '0;
                  end else begin
                     lin  <= d.base + BASE_W'(off_q);
                     attr <= d.attr;
                  end
               end
            end
            default: st <= C_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/segxl_unit.sv
`timescale 1ns/1ps
module segxl_unit
   import segxl_pkg::*;
#(
   parameter int MEM_W = 32,
   parameter int OFF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gtab_wr,
   input  logic [31:0]       gtab_base_in,
   input  logic [15:0]       gtab_lim_in,
   input  logic              ltsel_wr,
   input  logic [15:0]       ltsel_in,
   input  logic              xl_go,
   input  logic [15:0]       xl_sel,
   input  logic [OFF_W-1:0]  xl_off,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [31:0]       lin_addr,
   output logic [15:0]       attr_out,
   output logic [1:0]        rpl_out,
   output logic              mrd_valid,
   output logic [31:0]       mrd_addr,
   input  logic              mrd_ready,
   input  logic              mrd_rvalid,
   input  logic [MEM_W-1:0]  mrd_rdata
);
   initial begin
      assert (OFF_W >= 1 && OFF_W <= BASE_W)
         else $error("segxl_unit: OFF_W out of range");
   end

   tab_t              gtab;
   tab_t              ltab;
   tab_t              lnew;
   logic              lvld;
   logic              gwr_ok;
   logic              lld;
   logic              lfail;
   logic              fstart;
   logic [BASE_W-1:0] faddr;
   logic              fdone;
   logic [DESC_W-1:0] fdesc;

   segxl_tabs u_tabs (
      .clk   (clk),
      .rst_n (rst_n),
      .gwr   (gwr_ok),
      .gbase (gtab_base_in),
      .glim  (gtab_lim_in),
      .lld   (lld),
      .lfail (lfail),
      .lnew  (lnew),
      .gtab  (gtab),
      .ltab  (ltab),
      .lvld  (lvld)
   );

   segxl_ctrl #(.OFF_W(OFF_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .gwr    (gtab_wr),
      .lwr    (ltsel_wr),
      .lsel   (ltsel_in),
      .go     (xl_go),
      .xsel   (xl_sel),
      .xoff   (xl_off),
      .gtab   (gtab),
      .ltab   (ltab),
      .lvld   (lvld),
      .fdone  (fdone),
      .fdesc  (fdesc),
      .fstart (fstart),
      .faddr  (faddr),
      .gwr_ok (gwr_ok),
      .lld    (lld),
      .lfail  (lfail),
      .lnew   (lnew),
      .busy   (busy),
      .done   (done),
      .fault  (fault),
      .lin    (lin_addr),
      .attr   (attr_out),
      .rpl    (rpl_out)
   );

   segxl_fetch #(.MEM_W(MEM_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (fstart),
      .addr       (faddr),
      .mrd_valid  (mrd_valid),
      .mrd_addr   (mrd_addr),
      .mrd_ready  (mrd_ready),
      .mrd_rvalid (mrd_rvalid),
      .mrd_rdata  (mrd_rdata),
      .fdone      (fdone),
      .fdesc      (fdesc)
   );
endmodule

// File: rtl/segxl_chk.sv
`timescale 1ns/1ps
module segxl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        done,
   input logic        fault,
   input logic [31:0] lin_addr,
   input logic [15:0] attr_out,
   input logic        mrd_valid,
   input logic        mrd_ready,
   input logic [31:0] mrd_addr
);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_fault_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);

   assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (lin_addr == 32'd0 && attr_out == 16'd0));

   assert_req_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mrd_valid |-> busy);

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));
endmodule

bind segxl_unit segxl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .fault     (fault),
   .lin_addr  (lin_addr),
   .attr_out  (attr_out),
   .mrd_valid (mrd_valid),
   .mrd_ready (mrd_ready),
   .mrd_addr  (mrd_addr)
);

// File: tb/sim_segxl_unit.sv
`timescale 1ns/1ps
module sim_segxl_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        gtab_wr, ltsel_wr, xl_go;
   logic [31:0] gtab_base_in, xl_off;
   logic [15:0] gtab_lim_in, ltsel_in, xl_sel;
   logic        busy, done, fault, mrd_valid, mrd_ready, mrd_rvalid;
   logic [31:0] lin_addr, mrd_addr, mrd_rdata;
   logic [15:0] attr_out;
   logic [1:0]  rpl_out;

   always #5 clk = ~clk;

   segxl_unit u0 (.*);

   int n_chk = 0, n_bad = 0;
   int req_cnt = 0, done_cnt = 0, idle_req = 0;
   logic [31:0] a0 = 0, a1 = 0;
   logic [31:0] mem [0:1023];

   logic [31:0] m_gbase = 0, m_lbase = 0;
   logic [15:0] m_glim = 0, m_llim = 0;
   bit          m_lvld = 0;

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem[a[11:2]];
   endfunction

   task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
      end
   endtask

   // memory responder: decides at negedge, handshake happens at next posedge
   int          rsp_cnt = 0;
   bit          rsp_busy = 0;
   logic [31:0] rsp_addr = 0;
   initial begin
      mrd_ready = 0; mrd_rvalid = 0; mrd_rdata = 0;
      forever begin
         @(negedge clk);
         mrd_rvalid = 0;
         if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
               mrd_rvalid = 1;
               mrd_rdata  = rd(rsp_addr);
               rsp_busy   = 0;
            end
         end
         if (mrd_valid && !busy) idle_req++;
         if (mrd_valid && !rsp_busy && ($urandom % 3 != 0)) begin
            mrd_ready = 1;
            rsp_addr  = mrd_addr;
            rsp_cnt   = 1 + ($urandom % 3);
            rsp_busy  = 1;
            req_cnt++;
            a0 = a1;
            a1 = mrd_addr;
         end else begin
            mrd_ready = 0;
         end
      end
   end

   always @(negedge clk) if (done) done_cnt++;

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 act=timeout exp=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   task automatic run_cmd(input bit ld, input logic [15:0] sel, input logic [31:0] off, input string tag);
      bit          ef, tloc;
      logic [31:0] el, eaddr, w0, w1, tb;
      logic [15:0] ea, tl;
      logic [12:0] idx;
      int          er, rq0, dc0, t;
      idx = sel[15:3];
      tloc = ld ? 1'b0 : sel[2];
      ef = 0; el = 0; ea = 0; er = 0; eaddr = 0; w0 = 0; w1 = 0;
      if (tloc && !m_lvld) ef = 1;
      else begin
         tb = tloc ? m_lbase : m_gbase;
         tl = tloc ? m_llim : m_glim;
         if ({16'd0, idx, 3'b111} > {16'd0, tl}) ef = 1;
         else begin
            er = 2;
            eaddr = tb + {16'd0, idx, 3'b000};
            w0 = rd(eaddr);
            w1 = rd(eaddr + 4);
            if (ld) begin el = w0; ea = w1[31:16]; end
            else if (off > {16'd0, w1[15:0]}) ef = 1;
            else begin el = w0 + off; ea = w1[31:16]; end
         end
      end
      if (ld) begin
         if (ef) m_lvld = 0;
         else begin m_lvld = 1; m_lbase = w0; m_llim = w1[15:0]; end
      end
      while (busy) @(negedge clk);
      rq0 = req_cnt; dc0 = done_cnt;
      if (ld) begin ltsel_wr = 1; ltsel_in = sel; end
      else begin xl_go = 1; xl_sel = sel; xl_off = off; end
      @(negedge clk);
      ltsel_wr = 0; xl_go = 0;
      t = 0;
      while (!done && t < 400) begin @(negedge clk); t++; end
      chk(done == 1'b1, {tag, " R10 done seen"}, 32'(done), 1);
      chk(fault == ef, {tag, " fault"}, 32'(fault), 32'(ef));
      chk(lin_addr == el, {tag, " R3 lin_addr"}, lin_addr, el);
      chk(attr_out == ea, {tag, " R3 attr_out"}, 32'(attr_out), 32'(ea));
      chk(rpl_out == sel[1:0], {tag, " R1 rpl_out"}, 32'(rpl_out), 32'(sel[1:0]));
      chk(req_cnt - rq0 == er, {tag, " R5 request count"}, 32'(req_cnt - rq0), 32'(er));
      if (er == 2) begin
         chk(a0 == eaddr, {tag, " R2 first word addr"}, a0, eaddr);
         chk(a1 == eaddr + 4, {tag, " R2 second word addr"}, a1, eaddr + 4);
      end
      @(negedge clk);
      chk(done == 1'b0, {tag, " R10 one-cycle pulse"}, 32'(done), 0);
      chk(done_cnt - dc0 == 1, {tag, " R10 single pulse"}, 32'(done_cnt - dc0), 1);
   endtask

   task automatic gwrite(input logic [31:0] b, input logic [15:0] l);
      while (busy) @(negedge clk);
      gtab_wr = 1; gtab_base_in = b; gtab_lim_in = l;
      @(negedge clk);
      gtab_wr = 0;
      m_gbase = b; m_glim = l;
   endtask

   function automatic logic [15:0] peek_lim(input bit tloc, input logic [12:0] idx);
      logic [31:0] tb;
      tb = tloc ? m_lbase : m_gbase;
      return rd(tb + {16'd0, idx, 3'b000} + 4)[15:0];
   endfunction

   initial begin
      int dc0, rq0;
      logic [15:0] lim;
      logic [31:0] off;
      void'($urandom(32'd7041));
      rst_n = 0; gtab_wr = 0; ltsel_wr = 0; xl_go = 0;
      gtab_base_in = 0; gtab_lim_in = 0; ltsel_in = 0; xl_sel = 0; xl_off = 0;
      for (int i = 0; i < 1024; i++) mem[i] = $urandom;
      for (int i = 0; i < 20; i++) mem[64 + 2*i + 1][15:0] = 16'($urandom % 2048);
      mem[64 + 6] = 32'h0000_0400;
      mem[64 + 7] = {16'hA5C3, 16'd127};
      mem[64 + 2] = 32'h1234_0000;
      mem[64 + 3] = {16'h00F2, 16'h0100};

      repeat (3) @(negedge clk);
      chk(busy == 0, "R9 busy after reset", 32'(busy), 0);
      chk(done == 0, "R9 done after reset", 32'(done), 0);
      chk(fault == 0, "R9 fault after reset", 32'(fault), 0);
      chk(mrd_valid == 0, "R9 no request after reset", 32'(mrd_valid), 0);
      rst_n = 1;
      @(negedge clk);

      run_cmd(0, {13'd0, 1'b0, 2'd0}, 32'd0, "R9 global limit zero");
      run_cmd(0, {13'd0, 1'b1, 2'd2}, 32'd0, "R7 local before load");

      gwrite(32'h100, 16'd159);
      run_cmd(0, {13'd19, 1'b0, 2'd1}, 32'd0, "R5 last entry");
      run_cmd(0, {13'd20, 1'b0, 2'd1}, 32'd0, "R5 past table");
      run_cmd(0, {13'd1, 1'b0, 2'd3}, 32'h100, "R4 offset at limit");
      run_cmd(0, {13'd1, 1'b0, 2'd0}, 32'h101, "R4 offset above limit");
      run_cmd(0, {13'd1, 1'b0, 2'd3}, 32'h0, "R1 privilege three");

      run_cmd(1, {13'd3, 1'b1, 2'd1}, 32'd0, "R6 load local");
      run_cmd(0, {13'd2, 1'b1, 2'd0}, 32'd5, "R6 local access");
      run_cmd(0, {13'd15, 1'b1, 2'd0}, 32'd0, "R5 local last entry");
      run_cmd(0, {13'd16, 1'b1, 2'd0}, 32'd0, "R5 local past table");
      run_cmd(1, {13'd25, 1'b0, 2'd0}, 32'd0, "R6 load out of bounds");
      run_cmd(0, {13'd2, 1'b1, 2'd0}, 32'd5, "R7 local after failed load");
      run_cmd(1, {13'd3, 1'b0, 2'd0}, 32'd0, "R6 reload local");

      // R8: commands while busy are ignored
      while (busy) @(negedge clk);
      dc0 = done_cnt;
      xl_go = 1; xl_sel = {13'd4, 1'b0, 2'd0}; xl_off = 32'd0;
      @(negedge clk);
      xl_sel = {13'd6, 1'b1, 2'd3}; gtab_wr = 1; gtab_base_in = 32'h300; gtab_lim_in = 16'd500;
      ltsel_wr = 1; ltsel_in = {13'd30, 1'b0, 2'd0};
      @(negedge clk);
      @(negedge clk);
      xl_go = 0; gtab_wr = 0; ltsel_wr = 0;
      repeat (40) @(negedge clk);
      chk(done_cnt - dc0 == 1, "R8 one result while busy", 32'(done_cnt - dc0), 1);
      chk(rpl_out == 2'd0, "R8 result from first selector", 32'(rpl_out), 0);
      chk(lin_addr == rd(32'h100 + 32) + 0, "R8 first command address", lin_addr, rd(32'h120));
      run_cmd(0, {13'd4, 1'b0, 2'd2}, 32'd3, "R8 global table unchanged");
      run_cmd(0, {13'd2, 1'b1, 2'd2}, 32'd3, "R8 local table unchanged");

      // R8: priority in an idle cycle
      while (busy) @(negedge clk);
      dc0 = done_cnt; rq0 = req_cnt;
      gtab_wr = 1; gtab_base_in = 32'h200; gtab_lim_in = 16'd7;
      ltsel_wr = 1; ltsel_in = {13'd0, 1'b0, 2'd0};
      xl_go = 1; xl_sel = {13'd0, 1'b0, 2'd0}; xl_off = 0;
      @(negedge clk);
      gtab_wr = 0; ltsel_wr = 0; xl_go = 0;
      m_gbase = 32'h200; m_glim = 16'd7;
      repeat (20) @(negedge clk);
      chk(done_cnt == dc0, "R8 table write wins, R10 no pulse", 32'(done_cnt - dc0), 0);
      chk(req_cnt == rq0, "R8 no fetch after table write", 32'(req_cnt - rq0), 0);
      run_cmd(0, {13'd0, 1'b0, 2'd1}, 32'd0, "R8 new global base");
      run_cmd(0, {13'd1, 1'b0, 2'd1}, 32'd0, "R5 new global limit");
      run_cmd(0, {13'd2, 1'b1, 2'd1}, 32'd9, "R6 local kept");
      gwrite(32'h100, 16'd159);

      for (int k = 0; k < 60; k++) begin
         int r;
         bit tl;
         logic [12:0] ix;
         r = $urandom % 8;
         if (r == 0) run_cmd(1, {13'($urandom % 24), 1'b0, 2'($urandom)}, 0, "R6 random load");
         else if (r == 1) run_cmd(1, {13'd3, 1'b0, 2'd0}, 0, "R6 restore local");
         else begin
            tl = 1'($urandom);
            ix = 13'($urandom % (tl ? 18 : 22));
            lim = peek_lim(tl, ix);
            case ($urandom % 4)
               0: off = {16'd0, lim};
               1: off = {16'd0, lim} + 1;
               2: off = $urandom % ({16'd0, lim} + 1);
               default: off = $urandom;
            endcase
            run_cmd(0, {ix, tl, 2'($urandom)}, off, "R3 random translate");
         end
      end

      chk(idle_req == 0, "R11 requests only while busy", 32'(idle_req), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule